// File: doc/BRIEF.md
# Synchronized Multi-Channel Counter Group

This block keeps six 16-bit up-counters behind a small register bus, together with a synchronization register. The synchronization register holds one bit per channel. A channel whose bit is clear runs on its own. A channel whose bit is set joins a shared group. Grouping only takes effect when two or more bits are set.

Inside an active group, a bus write to any member's counter loads that value into every member at once. A member whose clear-source field selects the group option is zeroed in the same cycle that any other member clears on its own compare match.

Each channel has a count-enable input and a compare-match input. The compare-match input is that channel's local clear event. A second configuration register holds a 2-bit clear-source field for each channel. Reads have no side effects.

Top module: `sync_cnt_group`

## Requirements
- R1: After reset, every counter, the synchronization register (address 8) and the clear-source register (address 9) read 0.
- R2: Only bits 5..0 of the synchronization register are stored; on read, bits 15..6 always return 0, and a write to those bits has no effect.
- R3: A counter whose count enable is high, with no write and no clear, adds one on each clock and wraps from 0xFFFF to 0x0000; with enable low it holds.
- R4: A write to counter address n (0..5) of a channel outside the active group loads only that counter; no other counter changes.
- R5: With two or more sync bits set, a write to the counter address of any channel whose sync bit is 1 loads the same value into every channel whose sync bit is 1. The new value is readable on the next cycle.
- R6: With exactly one sync bit set, that channel behaves as independent: its writes and clears affect only itself.
- R7: A clear-source field equal to 01 (field n at bits 2n+1..2n of address 9) zeroes counter n on the cycle after its compare-match input is high.
- R8: A channel in an active group whose field is 10 is zeroed on the same edge as any other active-group channel with field 01 and compare match high. Channels that are not grouped, or that have another field value, are not cleared by this event.
- R9: Field values 00 and 11 never clear the counter.
- R10: Per channel, a load by bus write wins over a clear, and a clear wins over an increment.
- R11: Reading any address leaves all counters and registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 4 | Register address: 0..5 counters, 8 sync, 9 clear source |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| cnt_en_i | input | 6 | Per-channel count enable |
| cmp_match_i | input | 6 | Per-channel compare-match clear event |

## Verification
Several properties are checked on every cycle: the step-or-hold behaviour of each counter, the load of the addressed counter after a write, the local clear, the group clear of members whose field is 10, and the zero upper bits of the synchronization read. The bench covers what needs a whole configuration to be set up. It sweeps all 64 synchronization patterns against a write to every channel and against a clear from every channel. It checks that non-members stay untouched, that a lone sync bit behaves as independent, and how write, clear and increment interact within one cycle.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;
  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_LOCAL = 2'b01,
    CLR_GROUP = 2'b10,
    CLR_RSVD  = 2'b11
  } clr_sel_e;
endpackage

// File: rtl/sync_cnt_ctrl.sv
module sync_cnt_ctrl
  import sync_cnt_pkg::*;
#(
  parameter int unsigned NUM_CH    = 6,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SYNC_ADDR = 8,
  parameter int unsigned MODE_ADDR = 9,
  localparam int unsigned MODE_W   = 2 * NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MODE_W-1:0] cfg_wdata_i,
  output logic [NUM_CH-1:0] sync_q_o,
  output logic [MODE_W-1:0] mode_q_o,
  output logic [NUM_CH-1:0] grp_o
);
  logic [NUM_CH-1:0] sync_q;
  logic [MODE_W-1:0] mode_q;
  logic              grp_active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      mode_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(SYNC_ADDR)) sync_q <= cfg_wdata_i[NUM_CH-1:0];
      if (addr_i == ADDR_W'(MODE_ADDR)) mode_q <= cfg_wdata_i;
    end
  end

  // group exists only with two or more members
  always_comb begin
    int unsigned ones;
    ones = 0;
    for (int n = 0; n < NUM_CH; n++) ones += int'(sync_q[n]);
    grp_active = (ones >= 2);
  end

  assign grp_o    = grp_active ? sync_q : '0;
  assign sync_q_o = sync_q;
  assign mode_q_o = mode_q;
endmodule

// File: rtl/sync_cnt_fanout.sv
module sync_cnt_fanout
  import sync_cnt_pkg::*;
#(
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned MODE_W = 2 * NUM_CH
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_CH-1:0] grp_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NUM_CH-1:0] cmp_i,
  output logic [NUM_CH-1:0] load_o,
  output logic [NUM_CH-1:0] clr_o
);
  logic [NUM_CH-1:0] hit, loc_clr, grp_sel;
  logic              grp_wr, grp_evt;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    assign hit[n]     = we_i && (addr_i == ADDR_W'(n));
    assign loc_clr[n] = cmp_i[n] && (clr_sel_e'(mode_i[2*n +: 2]) == CLR_LOCAL);
    assign grp_sel[n] = grp_i[n] && (clr_sel_e'(mode_i[2*n +: 2]) == CLR_GROUP);
  end

  assign grp_wr  = |(hit & grp_i);
  assign grp_evt = |(loc_clr & grp_i);
  assign load_o  = hit | (grp_wr ? grp_i : '0);
  assign clr_o   = loc_clr | (grp_evt ? grp_sel : '0);
endmodule

// File: rtl/sync_cnt_chan.sv
module sync_cnt_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (clr_i)  cnt_o <= '0;
    else if (en_i)   cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/sync_cnt_group.sv
module sync_cnt_group
  import sync_cnt_pkg::*;
#(
  parameter int unsigned NUM_CH    = 6,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SYNC_ADDR = 8,
  parameter int unsigned MODE_ADDR = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0] cnt_en_i,
  input  logic [NUM_CH-1:0] cmp_match_i
);
  localparam int unsigned MODE_W = 2 * NUM_CH;

  logic [NUM_CH-1:0]       sync_q, grp, load, clr;
  logic [MODE_W-1:0]       mode_q;
  logic [NUM_CH*CNT_W-1:0] cnt_flat;

  sync_cnt_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SYNC_ADDR(SYNC_ADDR), .MODE_ADDR(MODE_ADDR)
  ) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .cfg_wdata_i(wdata_i[MODE_W-1:0]),
    .sync_q_o(sync_q), .mode_q_o(mode_q), .grp_o(grp)
  );

  sync_cnt_fanout #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_fanout (
    .we_i(we_i), .addr_i(addr_i), .grp_i(grp), .mode_i(mode_q),
    .cmp_i(cmp_match_i), .load_o(load), .clr_o(clr)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    sync_cnt_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load[n]), .load_val_i(wdata_i),
      .clr_i(clr[n]), .en_i(cnt_en_i[n]), .cnt_o(cnt_flat[n*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NUM_CH; n++)
      if (addr_i == ADDR_W'(n)) rdata_o = cnt_flat[n*CNT_W +: CNT_W];
    if (addr_i == ADDR_W'(SYNC_ADDR)) rdata_o = CNT_W'(sync_q);
    if (addr_i == ADDR_W'(MODE_ADDR)) rdata_o = CNT_W'(mode_q);
  end
endmodule

// File: rtl/sync_cnt_group_chk.sv
module sync_cnt_group_chk #(
  parameter int unsigned NUM_CH    = 6,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned SYNC_ADDR = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [CNT_W-1:0]        wdata_i,
  input logic [CNT_W-1:0]        rdata_o,
  input logic [NUM_CH-1:0]       cnt_en_i,
  input logic [NUM_CH-1:0]       cmp_match_i,
  input logic [NUM_CH-1:0]       sync_q,
  input logic [2*NUM_CH-1:0]     mode_q,
  input logic [NUM_CH*CNT_W-1:0] cnt_flat
);
  logic [NUM_CH-1:0] src_mask;
  always_comb
    for (int n = 0; n < NUM_CH; n++) src_mask[n] = (mode_q[2*n +: 2] == 2'b01);

  AST_SYNC_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(SYNC_ADDR) |-> rdata_o == CNT_W'(sync_q)); // R2

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ast
    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i && cmp_match_i == '0 && cnt_en_i[n]
      |=> cnt_flat[n*CNT_W +: CNT_W] == CNT_W'($past(cnt_flat[n*CNT_W +: CNT_W]) + 1)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i && cmp_match_i == '0 && !cnt_en_i[n]
      |=> $stable(cnt_flat[n*CNT_W +: CNT_W])); // R3
    AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && addr_i == ADDR_W'(n)
      |=> cnt_flat[n*CNT_W +: CNT_W] == $past(wdata_i)); // R10
    AST_LOCAL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i && cmp_match_i[n] && mode_q[2*n +: 2] == 2'b01
      |=> cnt_flat[n*CNT_W +: CNT_W] == '0); // R7
    AST_GROUP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i && $countones(sync_q) >= 2 && sync_q[n] && mode_q[2*n +: 2] == 2'b10
      && |(cmp_match_i & sync_q & src_mask)
      |=> cnt_flat[n*CNT_W +: CNT_W] == '0); // R8
  end
endmodule

bind sync_cnt_group sync_cnt_group_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SYNC_ADDR(SYNC_ADDR)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .cnt_en_i(cnt_en_i), .cmp_match_i(cmp_match_i),
  .sync_q(sync_q), .mode_q(mode_q), .cnt_flat(cnt_flat)
);

// File: tb/test_sync_cnt_group.sv
`timescale 1ns/100ps
module test_sync_cnt_group;
  localparam int NCH = 6, CW = 16, AW = 4, SA = 8, MA = 9;

  logic          clk = 0, rst_ni = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0, rdata;
  logic [NCH-1:0] en = '0, cmp = '0;

  logic [CW-1:0]    m_cnt [NCH];
  logic [NCH-1:0]   m_sync;
  logic [2*NCH-1:0] m_mode;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_cnt_group i_sync_cnt_group (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cnt_en_i(en), .cmp_match_i(cmp)
  );

  task automatic check(string tag, logic [CW-1:0] got, logic [CW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic peek(logic [AW-1:0] a, output logic [CW-1:0] v);
    addr = a; #0.5; v = rdata;
  endtask

  task automatic verify_all(string tag);
    logic [CW-1:0] v;
    for (int n = 0; n < NCH; n++) begin
      peek(AW'(n), v); check(tag, v, m_cnt[n]);
    end
    peek(AW'(SA), v); check(tag, v, CW'(m_sync));
    peek(AW'(MA), v); check(tag, v, CW'(m_mode));
  endtask

  // bench reference, built from the requirements
  task automatic cycle(logic w, logic [AW-1:0] a, logic [CW-1:0] d,
                       logic [NCH-1:0] e, logic [NCH-1:0] c);
    logic [CW-1:0] nxt [NCH];
    logic [NCH-1:0] grp, hit, loc;
    logic gwr, gevt;
    grp = ($countones(m_sync) >= 2) ? m_sync : '0;
    for (int n = 0; n < NCH; n++) begin
      hit[n] = w && a == AW'(n);
      loc[n] = c[n] && m_mode[2*n +: 2] == 2'b01;
    end
    gwr = |(hit & grp);
    gevt = |(loc & grp);
    for (int n = 0; n < NCH; n++) begin
      if (hit[n] || (grp[n] && gwr)) nxt[n] = d;
      else if (loc[n] || (grp[n] && m_mode[2*n +: 2] == 2'b10 && gevt)) nxt[n] = '0;
      else if (e[n]) nxt[n] = m_cnt[n] + 1'b1;
      else nxt[n] = m_cnt[n];
    end
    we = w; addr = a; wdata = d; en = e; cmp = c;
    @(posedge clk); #1;
    we = 0; en = '0; cmp = '0;
    for (int n = 0; n < NCH; n++) m_cnt[n] = nxt[n];
    if (w && a == AW'(SA)) m_sync = d[NCH-1:0];
    if (w && a == AW'(MA)) m_mode = d[2*NCH-1:0];
  endtask

  task automatic wr(logic [AW-1:0] a, logic [CW-1:0] d);
    cycle(1'b1, a, d, '0, '0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v1, v2;
    string tag;
    for (int n = 0; n < NCH; n++) m_cnt[n] = '0;
    m_sync = '0; m_mode = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    verify_all("R1");

    // R2 reserved sync bits
    wr(AW'(SA), 16'hFFFF); verify_all("R2");
    peek(AW'(SA), v1); check("R2", v1, 16'h003F);
    wr(AW'(SA), 16'h00C0); verify_all("R2");
    peek(AW'(SA), v1); check("R2", v1, 16'h0000);

    // R3 count and wrap
    wr(AW'(0), 16'hFFFE); wr(AW'(3), 16'h1234);
    cycle(1'b0, '0, '0, 6'b000001, '0); verify_all("R3");
    cycle(1'b0, '0, '0, 6'b001001, '0); verify_all("R3");
    peek(AW'(0), v1); check("R3", v1, 16'h0000);
    cycle(1'b0, '0, '0, 6'b000000, '0); verify_all("R3");

    // R11 reads are side-effect free
    peek(AW'(3), v1); peek(AW'(3), v2); check("R11", v2, v1);
    verify_all("R11");

    // R4/R5/R6 write sweep over all sync patterns
    for (int s = 0; s < 64; s++) begin
      wr(AW'(SA), CW'(s));
      for (int k = 0; k < NCH; k++) begin
        if ($countones(s) >= 2 && s[k]) tag = "R5";
        else if ($countones(s) == 1 && s[k]) tag = "R6";
        else tag = "R4";
        wr(AW'(k), CW'(s * 16'h0107 + k * 16'h1111 + 1));
        verify_all(tag);
      end
    end

    // R7 local clear, R9 reserved/none
    wr(AW'(SA), 16'h0000);
    for (int n = 0; n < NCH; n++) wr(AW'(n), CW'(16'h0100 + n));
    wr(AW'(MA), 16'b00_00_11_00_01_00); // ch1 local, ch3 reserved
    cycle(1'b0, '0, '0, 6'b111111, 6'b001010); verify_all("R7");
    peek(AW'(1), v1); check("R7", v1, 16'h0000);
    peek(AW'(3), v1); check("R9", v1, 16'h0104);

    // R8/R9 clear sweep: every pattern, every source channel
    for (int s = 0; s < 64; s++) begin
      for (int src = 0; src < NCH; src++) begin
        logic [2*NCH-1:0] md;
        wr(AW'(SA), 16'h0000);
        for (int n = 0; n < NCH; n++) wr(AW'(n), CW'(16'h0A00 + s + n * 16'h0040));
        md = '0;
        for (int j = 0; j < NCH; j++)
          md[2*j +: 2] = (j == src) ? 2'b01 : (((j + s) % 3 == 0) ? 2'b11 : 2'b10);
        wr(AW'(MA), CW'(md));
        wr(AW'(SA), CW'(s));
        cycle(1'b0, '0, '0, 6'b111111, NCH'(1 << src));
        verify_all("R8");
      end
    end

    // R10 write beats clear beats increment
    wr(AW'(SA), 16'h0000);
    wr(AW'(MA), 16'b10_10_10_10_01_01);
    wr(AW'(SA), 16'h0007); // ch0..2 grouped
    for (int n = 3; n < NCH; n++) wr(AW'(n), 16'h0055);
    cycle(1'b1, AW'(0), 16'hBEEF, 6'b111111, 6'b000011);
    verify_all("R10");
    peek(AW'(2), v1); check("R10", v1, 16'hBEEF);
    cycle(1'b1, AW'(4), 16'h7777, 6'b111111, 6'b000010);
    verify_all("R10");
    peek(AW'(2), v1); check("R10", v1, 16'h0000);
    peek(AW'(4), v1); check("R10", v1, 16'h7777);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule